// File: doc/BRIEF.md
# Vector-Programmed Bus Waveform Sequencer

This block masters a local parallel bus toward an external device. The bus timing is not built into the logic. It comes from a small table of vectors that is loaded through a write port. A vector does one of two things. A drive vector puts a 6-bit pattern on the control lines and holds it for a chosen number of clocks. A wait vector stalls until a masked pattern matches on six ready inputs. When a vector is marked as a data strobe, the block either captures one word from the input data bus or presents one word on the output data bus. After each such access the address output steps by one.

A one-cycle start pulse runs the table from entry 0 to the first entry marked last, or to the final entry. When the waveform completes, a one-clock done pulse marks the end. If a wait vector never sees its condition, it is cut off by a programmable timeout. The timeout aborts the waveform and raises an error flag, which stays set until the next start. A width select chooses a 16-bit data path or an 8-bit path that uses only the low byte.

Top module: `vector_wave_engine`

## Requirements
- R1: A vector is 29 bits wide. It is written into entry `vecWrAddr` on the clock edge where `vecWrEn` is high. Bit layout: 28:23 control value, 22 wait opcode (1 = wait, 0 = drive), 21:16 ready mask, 15:10 ready match, 9 data strobe, 8 last, 7:0 hold count.
- R2: A `start` pulse while idle begins the waveform at entry 0. `busy` goes high from the next cycle until the waveform ends. A `start` pulse while busy has no effect on the waveform length.
- R3: A drive vector with hold count h shows its control value on `ctlOut` for exactly h+1 clocks (1 to 256), then the next vector begins.
- R4: During a wait vector, `ctlOut` keeps the last value a drive vector put out (0 after reset). The vector completes in the cycle where `((rdyIn ^ match) & mask) == 0`. Ready bits whose mask bit is clear are ignored.
- R5: If a wait vector's condition is still false in its cycle with index `timeoutLimit` (counting from 0), the waveform aborts. `busy` falls, `timeoutErr` sets, and no done pulse follows. The next start clears `timeoutErr`.
- R6: With `readMode` = 1, a strobe vector captures `dataIn` in its final cycle. `rxData` and a one-cycle `rxValid` pulse appear in the next cycle. When `wide16` = 0, the upper byte of `rxData` is zero.
- R7: With `readMode` = 0, `dataOe` is high while busy. `txTake` is high in the final cycle of each strobe vector. `dataOut` carries `txData`, with the upper byte forced to zero when `wide16` = 0.
- R8: `adrOut` loads `startAdr` at start and increments by one (modulo 64) after each strobe access. Otherwise it holds.
- R9: After the vector marked last completes, `done` is high for exactly one clock and the block is idle in that same cycle.
- R10: The final table entry (index 7) ends the waveform even when its last bit is clear.
- R11: After reset, `ctlOut`, `busy`, `done`, `timeoutErr`, `rxValid` and `txTake` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vecWrEn | input | 1 | Vector table write enable |
| vecWrAddr | input | 3 | Vector table entry to write |
| vecWrData | input | 29 | Vector contents |
| start | input | 1 | Run one waveform |
| wide16 | input | 1 | 1 = 16-bit data path, 0 = low byte only |
| readMode | input | 1 | 1 = strobes capture data, 0 = strobes present data |
| startAdr | input | 6 | Address loaded at start |
| timeoutLimit | input | 16 | Last allowed wait cycle index |
| rdyIn | input | 6 | Ready inputs from the external device |
| dataIn | input | 16 | Data bus from the device |
| txData | input | 16 | Word to present on writes |
| ctlOut | output | 6 | Control lines |
| adrOut | output | 6 | Address lines |
| dataOut | output | 16 | Data bus toward the device |
| dataOe | output | 1 | Output enable for dataOut |
| txTake | output | 1 | Current txData word is consumed this cycle |
| rxData | output | 16 | Last captured word |
| rxValid | output | 1 | rxData updated this cycle |
| busy | output | 1 | Waveform in progress |
| done | output | 1 | One-clock end-of-waveform pulse |
| timeoutErr | output | 1 | Last waveform aborted on a wait timeout |

## Verification
The properties assume that `rdyIn` is already synchronous to `clk`. They also assume that nothing rewrites the table while `busy` is high, and that `wide16` and `readMode` stay fixed during a waveform. If any of these changed mid-run, the bound on the hold counter and the held control value could shift under the checks. The stimulus loads every vector and sets the mode inputs while the block is idle, and it changes `rdyIn` and `dataIn` only between clock edges.

// File: rtl/vwe_pkg.sv
`timescale 1ns/1ps
package vwe_pkg;
  localparam int CTL_W  = 6;
  localparam int RDY_W  = 6;
  localparam int HOLD_W = 8;

  // sequencing part of a vector, used by the control
  typedef struct packed {
    logic              isWait;
    logic [RDY_W-1:0]  mask;
    logic [RDY_W-1:0]  match;
    logic              strobe;
    logic              last;
    logic [HOLD_W-1:0] hold;
  } seq_t;

  typedef struct packed {
    logic [CTL_W-1:0] ctl;
    seq_t             seq;
  } vec_t;

  localparam int VEC_W = $bits(vec_t);

  // strobes from control to datapath
  typedef struct packed {
    logic loadStart;
    logic active;
    logic drive;
    logic access;
  } strb_t;
endpackage

// File: rtl/vwe_ctrl.sv
`timescale 1ns/1ps
module vwe_ctrl
  import vwe_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int TO_W    = 16,
  localparam int PTR_W  = $clog2(NUM_VEC)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  seq_t             cur,
  input  logic [RDY_W-1:0] rdyIn,
  input  logic [TO_W-1:0]  timeoutLimit,
  output logic [PTR_W-1:0] ptr,
  output strb_t            strb,
  output logic             busy,
  output logic             done,
  output logic             timeoutErr
);
  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  state_t          state;
  logic [TO_W-1:0] cnt;
  logic            run;
  logic            condMet;
  logic            holdEnd;
  logic            finish;
  logic            atEnd;
  logic            expire;

  always_comb begin
    run     = (state == ST_RUN);
    condMet = ((rdyIn ^ cur.match) & cur.mask) == '0;
    holdEnd = (cnt == TO_W'(cur.hold));
    finish  = run && (cur.isWait ? condMet : holdEnd);
    atEnd   = cur.last || (ptr == PTR_W'(NUM_VEC - 1));
    expire  = run && cur.isWait && !condMet && (cnt == timeoutLimit);

    strb.loadStart = !run && start;
    strb.active    = run;
    strb.drive     = run && !cur.isWait;
    strb.access    = finish && cur.strobe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      ptr        <= '0;
      cnt        <= '0;
      done       <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      done <= finish && atEnd;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state      <= ST_RUN;
            ptr        <= '0;
            cnt        <= '0;
            timeoutErr <= 1'b0;
          end
        end
        default: begin
          if (finish) begin
            cnt <= '0;
            if (atEnd) state <= ST_IDLE;
            else       ptr   <= ptr + 1'b1;
          end else if (expire) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            timeoutErr <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign busy = run;

  // R9: done is a single-clock pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R9: the block is idle while done is shown
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R2: a start while idle always launches a run
  a_r2_start_runs: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);
  // R5: an abort never comes with a done pulse
  a_r5_abort_no_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> (!busy && !done));
  // R3: hold counter never passes the vector's count
  a_r3_hold_bound: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cur.isWait) |-> (cnt <= TO_W'(cur.hold)));
endmodule

// File: rtl/vwe_datapath.sv
`timescale 1ns/1ps
module vwe_datapath
  import vwe_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int ADR_W   = 6,
  parameter int DATA_W  = 16,
  localparam int PTR_W  = $clog2(NUM_VEC),
  localparam int HALF   = DATA_W / 2,
  localparam int LANES  = DATA_W / HALF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vecWrEn,
  input  logic [PTR_W-1:0]  vecWrAddr,
  input  logic [VEC_W-1:0]  vecWrData,
  input  logic [PTR_W-1:0]  ptr,
  input  strb_t             strb,
  input  logic              wide16,
  input  logic              readMode,
  input  logic [ADR_W-1:0]  startAdr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] txData,
  output seq_t              curSeq,
  output logic [CTL_W-1:0]  ctlOut,
  output logic [ADR_W-1:0]  adrOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              txTake,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid
);
  vec_t              table_q [NUM_VEC];
  vec_t              cur;
  logic [CTL_W-1:0]  ctlHold;
  logic [DATA_W-1:0] laneMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_VEC; i++) table_q[i] <= '0;
    end else if (vecWrEn) begin
      table_q[vecWrAddr] <= vec_t'(vecWrData);
    end
  end

  assign cur    = table_q[ptr];
  assign curSeq = cur.seq;

  // lane 0 always live, upper lanes only in wide mode
  for (genvar ln = 0; ln < LANES; ln++) begin : gLane
    if (ln == 0) begin : gLow
      assign laneMask[ln*HALF +: HALF] = '1;
    end else begin : gHigh
      assign laneMask[ln*HALF +: HALF] = {HALF{wide16}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           ctlHold <= '0;
    else if (strb.drive) ctlHold <= cur.ctl;
  end

  assign ctlOut = strb.drive ? cur.ctl : ctlHold;

  always_ff @(posedge clk) begin
    if (!rstN)               adrOut <= '0;
    else if (strb.loadStart) adrOut <= startAdr;
    else if (strb.access)    adrOut <= adrOut + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= strb.access && readMode;
      if (strb.access && readMode) rxData <= dataIn & laneMask;
    end
  end

  assign txTake  = strb.access && !readMode;
  assign dataOe  = strb.active && !readMode;
  assign dataOut = txData & laneMask;

  // R8: one address step after each access
  a_r8_adr_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.access && !strb.loadStart) |=> (adrOut == ADR_W'($past(adrOut) + 1'b1)));
  // R8: address holds without access or start
  a_r8_adr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.access && !strb.loadStart) |=> $stable(adrOut));
  // R6: narrow captures leave the upper byte clear
  a_r6_rx_narrow: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !wide16) |-> (rxData[DATA_W-1:HALF] == '0));
  // R7: a consumed word is always on a driven bus
  a_r7_take_oe: assert property (@(posedge clk) disable iff (!rstN)
    txTake |-> dataOe);
  // R4: control lines stay put across a wait cycle
  a_r4_wait_keeps_ctl: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && !strb.drive && $past(strb.active)) |-> $stable(ctlOut));
endmodule

// File: rtl/vector_wave_engine.sv
`timescale 1ns/1ps
module vector_wave_engine
  import vwe_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int ADR_W   = 6,
  parameter int DATA_W  = 16,
  parameter int TO_W    = 16,
  localparam int PTR_W  = $clog2(NUM_VEC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vecWrEn,
  input  logic [PTR_W-1:0]  vecWrAddr,
  input  logic [VEC_W-1:0]  vecWrData,
  input  logic              start,
  input  logic              wide16,
  input  logic              readMode,
  input  logic [ADR_W-1:0]  startAdr,
  input  logic [TO_W-1:0]   timeoutLimit,
  input  logic [RDY_W-1:0]  rdyIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] txData,
  output logic [CTL_W-1:0]  ctlOut,
  output logic [ADR_W-1:0]  adrOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              txTake,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              busy,
  output logic              done,
  output logic              timeoutErr
);
  seq_t             curSeq;
  strb_t            strb;
  logic [PTR_W-1:0] ptr;

  vwe_ctrl #(.NUM_VEC(NUM_VEC), .TO_W(TO_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .cur(curSeq), .rdyIn(rdyIn),
    .timeoutLimit(timeoutLimit), .ptr(ptr), .strb(strb), .busy(busy),
    .done(done), .timeoutErr(timeoutErr)
  );

  vwe_datapath #(.NUM_VEC(NUM_VEC), .ADR_W(ADR_W), .DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .vecWrEn(vecWrEn), .vecWrAddr(vecWrAddr),
    .vecWrData(vecWrData), .ptr(ptr), .strb(strb), .wide16(wide16),
    .readMode(readMode), .startAdr(startAdr), .dataIn(dataIn), .txData(txData),
    .curSeq(curSeq), .ctlOut(ctlOut), .adrOut(adrOut), .dataOut(dataOut),
    .dataOe(dataOe), .txTake(txTake), .rxData(rxData), .rxValid(rxValid)
  );
endmodule

// File: tb/vector_wave_engine_test.sv
`timescale 1ns/1ps
module vector_wave_engine_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        vecWrEn = 1'b0;
  logic [2:0]  vecWrAddr = '0;
  logic [28:0] vecWrData = '0;
  logic        start = 1'b0;
  logic        wide16 = 1'b0;
  logic        readMode = 1'b1;
  logic [5:0]  startAdr = '0;
  logic [15:0] timeoutLimit = 16'd4;
  logic [5:0]  rdyIn = '0;
  logic [15:0] dataIn = '0;
  logic [15:0] txData = '0;
  logic [5:0]  ctlOut, adrOut;
  logic [15:0] dataOut, rxData;
  logic        dataOe, txTake, rxValid, busy, done, timeoutErr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  vector_wave_engine uut (
    .clk(clk), .rstN(rstN), .vecWrEn(vecWrEn), .vecWrAddr(vecWrAddr),
    .vecWrData(vecWrData), .start(start), .wide16(wide16), .readMode(readMode),
    .startAdr(startAdr), .timeoutLimit(timeoutLimit), .rdyIn(rdyIn),
    .dataIn(dataIn), .txData(txData), .ctlOut(ctlOut), .adrOut(adrOut),
    .dataOut(dataOut), .dataOe(dataOe), .txTake(txTake), .rxData(rxData),
    .rxValid(rxValid), .busy(busy), .done(done), .timeoutErr(timeoutErr)
  );

  // wait-condition table: mask, match, ready, expected pass
  localparam logic [18:0] WAIT_TBL [8] = '{
    {6'h3F, 6'h2A, 6'h2A, 1'b1},
    {6'h3F, 6'h2A, 6'h2B, 1'b0},
    {6'h00, 6'h3F, 6'h00, 1'b1},
    {6'h05, 6'h05, 6'h07, 1'b1},
    {6'h05, 6'h05, 6'h06, 1'b0},
    {6'h20, 6'h00, 6'h1F, 1'b1},
    {6'h20, 6'h00, 6'h3F, 1'b0},
    {6'h18, 6'h10, 6'h11, 1'b1}
  };

  function automatic logic [28:0] mkVec(input logic [5:0] ctl, input logic isWait,
      input logic [5:0] mask, input logic [5:0] match, input logic strobe,
      input logic last, input logic [7:0] hold);
    return {ctl, isWait, mask, match, strobe, last, hold};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeVec(input int idx, input logic [28:0] v);
    @(negedge clk);
    vecWrEn = 1'b1; vecWrAddr = 3'(idx); vecWrData = v;
    @(negedge clk);
    vecWrEn = 1'b0;
  endtask

  // returns at the negedge inside the first running cycle
  task automatic doStart;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int n;
    bit seen;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(ctlOut == 0 && busy == 0 && done == 0 && timeoutErr == 0 &&
        rxValid == 0 && txTake == 0, "R11 reset outputs",
        {ctlOut, busy, done, timeoutErr, rxValid, txTake}, 0);

    // R4 R5 table of wait conditions, one wait vector marked last
    timeoutLimit = 16'd4;
    for (int t = 0; t < 8; t++) begin
      writeVec(0, mkVec(6'h00, 1'b1, WAIT_TBL[t][18:13], WAIT_TBL[t][12:7], 1'b0, 1'b1, 8'd0));
      rdyIn = WAIT_TBL[t][6:1];
      doStart();
      chk(timeoutErr == 0, "R5 error cleared by start", timeoutErr, 0);
      seen = 0;
      for (int k = 0; k < 10; k++) begin
        if (done) seen = 1;
        @(negedge clk);
      end
      chk(seen == WAIT_TBL[t][0], "R4 wait condition pass", seen, WAIT_TBL[t][0]);
      chk(timeoutErr == !WAIT_TBL[t][0] && busy == 0, "R5 timeout flag",
          timeoutErr, !WAIT_TBL[t][0]);
    end

    // R5 exact timeout cycle: limit 4 gives 5 busy cycles
    writeVec(0, mkVec(6'h00, 1'b1, 6'h01, 6'h01, 1'b0, 1'b1, 8'd0));
    rdyIn = 6'h00;
    doStart();
    n = 0;
    while (busy && n < 50) begin n++; @(negedge clk); end
    chk(n == 5, "R5 wait abort cycle count", n, 5);
    chk(timeoutErr == 1 && done == 0, "R5 abort without done", {timeoutErr, done}, 2'b10);

    // R1 R3 R9 drive holds
    writeVec(0, mkVec(6'h2A, 1'b0, 6'h00, 6'h00, 1'b0, 1'b0, 8'd2));
    writeVec(1, mkVec(6'h15, 1'b0, 6'h00, 6'h00, 1'b0, 1'b1, 8'd0));
    doStart();
    for (int k = 0; k < 4; k++) begin
      chk(ctlOut == (k < 3 ? 6'h2A : 6'h15), "R3 drive hold sequence (R1 layout)",
          ctlOut, (k < 3 ? 6'h2A : 6'h15));
      @(negedge clk);
    end
    chk(done == 1 && busy == 0, "R9 done after last vector", {done, busy}, 2'b10);
    @(negedge clk);
    chk(done == 0 && ctlOut == 6'h15, "R9 done single clock", {done, ctlOut}, 7'h15);

    // R3 R2 maximum hold of 256 with a start pulse while busy
    writeVec(0, mkVec(6'h3F, 1'b0, 6'h00, 6'h00, 1'b0, 1'b1, 8'd255));
    doStart();
    n = 0; seen = 0;
    while (busy && n < 400) begin
      if (ctlOut != 6'h3F) seen = 1;
      n++;
      start = (n == 100);
      @(negedge clk);
    end
    start = 1'b0;
    chk(n == 256, "R3 hold 256 clocks; R2 start while busy ignored", n, 256);
    chk(seen == 0, "R3 control held during drive", seen, 0);
    chk(done == 1, "R9 done after long hold", done, 1);

    // R4 wait keeps previous control value
    timeoutLimit = 16'd1000;
    writeVec(0, mkVec(6'h0F, 1'b0, 6'h00, 6'h00, 1'b0, 1'b0, 8'd0));
    writeVec(1, mkVec(6'h30, 1'b1, 6'h01, 6'h01, 1'b0, 1'b1, 8'd0));
    rdyIn = 6'h00;
    doStart();
    @(negedge clk);
    seen = 0;
    for (int k = 0; k < 5; k++) begin
      if (ctlOut != 6'h0F || !busy) seen = 1;
      @(negedge clk);
    end
    chk(seen == 0, "R4 control held while waiting", seen, 0);
    rdyIn = 6'h01;
    @(negedge clk);
    chk(done == 1, "R4 wait released by ready", done, 1);

    // R6 R8 narrow read with address steps
    readMode = 1'b1; wide16 = 1'b0; startAdr = 6'd5; dataIn = 16'hABCD;
    writeVec(0, mkVec(6'h01, 1'b0, 6'h00, 6'h00, 1'b1, 1'b0, 8'd1));
    writeVec(1, mkVec(6'h02, 1'b0, 6'h00, 6'h00, 1'b1, 1'b1, 8'd0));
    doStart();
    chk(adrOut == 6'd5 && rxValid == 0 && dataOe == 0, "R8 address loaded at start",
        adrOut, 5);
    @(negedge clk);
    chk(rxValid == 0 && adrOut == 6'd5, "R6 no capture before final cycle", rxValid, 0);
    @(negedge clk);
    chk(rxValid == 1 && rxData == 16'h00CD, "R6 narrow capture", rxData, 16'h00CD);
    chk(adrOut == 6'd6, "R8 address step after access", adrOut, 6);
    dataIn = 16'h1234;
    @(negedge clk);
    chk(rxValid == 1 && rxData == 16'h0034, "R6 second capture", rxData, 16'h0034);
    chk(adrOut == 6'd7 && done == 1, "R8 second step", adrOut, 7);
    @(negedge clk);
    chk(rxValid == 0 && adrOut == 6'd7, "R6 rxValid single pulse; R8 hold", {rxValid, adrOut}, 7);

    // R6 wide read
    wide16 = 1'b1; dataIn = 16'hABCD;
    doStart();
    repeat (2) @(negedge clk);
    chk(rxValid == 1 && rxData == 16'hABCD, "R6 wide capture", rxData, 16'hABCD);
    repeat (3) @(negedge clk);

    // R7 narrow write
    readMode = 1'b0; wide16 = 1'b0; txData = 16'hBEEF;
    doStart();
    chk(dataOe == 1 && txTake == 0 && dataOut == 16'h00EF, "R7 narrow drive",
        {dataOe, txTake, dataOut}, 18'h200EF);
    @(negedge clk);
    chk(txTake == 1, "R7 take on first strobe", txTake, 1);
    @(negedge clk);
    chk(txTake == 1, "R7 take on second strobe", txTake, 1);
    @(negedge clk);
    chk(txTake == 0 && dataOe == 0, "R7 bus released when idle", {txTake, dataOe}, 0);
    wide16 = 1'b1;
    @(negedge clk);
    chk(dataOut == 16'hBEEF, "R7 wide data out", dataOut, 16'hBEEF);

    // R10 final entry ends the table
    for (int i = 0; i < 8; i++)
      writeVec(i, mkVec(6'(i), 1'b0, 6'h00, 6'h00, 1'b0, 1'b0, 8'd0));
    doStart();
    n = 0;
    while (busy && n < 50) begin
      n++;
      if (n == 8) chk(ctlOut == 6'd7, "R10 entry 7 reached", ctlOut, 7);
      @(negedge clk);
    end
    chk(n == 8 && done == 1, "R10 implicit end at final entry", n, 8);

    finish_run();
  end
endmodule